// File: doc/BRIEF.md
# Serial Flash Status Register and Write Guard

This block holds the status register of a serial NOR flash and decides which modifying commands may run. The register carries a sticky status-lock bit, a three-bit protect code, the write-enable latch and a busy flag. A command decoder in front of the block presents one-cycle strobes for write-enable, write-disable, status write, program and the three erase kinds, together with the target byte address and the new status field values. The block answers each modifying command with a one-cycle accept or reject pulse and updates its register.

Two guards apply. Status writes pass only with the latch set, and are refused when the lock bit is 1 while the active-low protect pin is low (hardware lock). Program and erase requests are refused when they fall in the region picked by the protect code, counted in 64 KB sectors down from the top of a 2 MB array. A small state machine tracks the lock mode: OPEN (lock bit 0), SOFT (lock bit 1, pin high) and HARD (lock bit 1, pin low). Its transitions are named OPEN->SOFT (lock set with pin high), OPEN->HARD (lock set with pin low), SOFT->HARD (pin falls), HARD->SOFT (pin rises, the only exit from HARD) and SOFT->OPEN (lock cleared by an accepted write). One strobe per cycle is expected. If several arrive together, the block uses the first in this list: status write, program, sector erase, page erase, bulk erase, write-enable, write-disable.

Top module: `flash_wp_ctrl`

## Requirements
- R1: After reset the lock bit, protect code, latch and busy flag are 0, the hardware-lock flag is 0 and no accept or reject pulse is present.
- R2: A write-enable strobe sets the latch and a write-disable strobe clears it. Neither produces an accept or reject pulse.
- R3: A status write with the latch clear is rejected and leaves the lock bit and protect code unchanged.
- R4: With the lock bit at 0, a status write with the latch set is accepted whatever the pin level. It loads the lock bit and protect code and clears the latch.
- R5: With the lock bit at 1 and the pin high, a status write with the latch set is accepted.
- R6: In hardware lock, a status write is rejected even with the latch set. The lock bit, protect code and latch are unchanged.
- R7: The hardware-lock output is 1 exactly when the lock bit is 1 and the pin was low at the last edge, whichever of the two came first. It clears only when the pin goes high, and the lock bit stays 1 throughout the lock.
- R8: Program, sector erase and page erase are rejected when the address sector (address bits 20:16) lies in the protected region. Code 0 protects nothing. Codes 1 to 5 protect the top 2^(code-1) sectors of the 32. Codes 6 and 7 protect all sectors. Requests outside the region that have the latch set are accepted.
- R9: A bulk erase is rejected when the protect code is nonzero, and is accepted with the latch set and code 0.
- R10: Every program or erase request clears the latch, whether accepted or rejected. Such a request with the latch clear is rejected.
- R11: An accepted status write, program or erase holds busy high for OP_CYCLES cycles. Commands arriving while busy is high are ignored: no pulse and no register change.
- R12: The pin is sampled at each edge. A status write arriving in the same cycle as a pin change is judged by the pin level taken at the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wp_n | input | 1 | Active-low write-protect pin |
| cmd_wren | input | 1 | Write-enable strobe |
| cmd_wrdi | input | 1 | Write-disable strobe |
| cmd_wrsr | input | 1 | Status write strobe |
| cmd_prog | input | 1 | Page program strobe |
| cmd_erase_sec | input | 1 | Sector erase strobe |
| cmd_erase_page | input | 1 | Page erase strobe |
| cmd_erase_bulk | input | 1 | Bulk erase strobe |
| addr | input | ADDR_W | Target byte address |
| wr_lockbit | input | 1 | New lock bit for a status write |
| wr_bp | input | 3 | New protect code for a status write |
| sr_lockbit | output | 1 | Status lock bit |
| sr_bp | output | 3 | Protect code |
| sr_wel | output | 1 | Write-enable latch |
| sr_busy | output | 1 | Operation in progress |
| hw_locked | output | 1 | Hardware lock active |
| op_accept | output | 1 | Command accepted (one-cycle pulse) |
| op_reject | output | 1 | Command refused (one-cycle pulse) |

## Verification
A pin change and a status write can land on the same clock edge. The write must then be judged by the mode built from the previous pin sample, while the lock mode after that edge follows the new pin and the new lock bit. The bench drives the pin and the write strobe in the same half cycle in both directions. Pin falling with the lock bit at 1 must still accept the write and then show hardware lock. Pin rising out of hardware lock must still reject the write and then show the lock cleared. A reference model in the driver forms the expected pulse and register image for each case.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;

    localparam int BP_W = 3;

    typedef enum logic [1:0] {
        MODE_OPEN = 2'd0,
        MODE_SOFT = 2'd1,
        MODE_HARD = 2'd2
    } wp_mode_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_WREN,
        OP_WRDI,
        OP_WRSR,
        OP_PROG,
        OP_ERASE_SEC,
        OP_ERASE_PAGE,
        OP_ERASE_BULK
    } op_e;

endpackage

// File: rtl/wp_mode_fsm.sv
module wp_mode_fsm
    import flash_wp_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     lock_nxt,
    input  logic     wp_n,
    output wp_mode_e mode,
    output logic     hard_lock
);

    wp_mode_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_OPEN: if (lock_nxt) state_d = wp_n ? MODE_SOFT : MODE_HARD;
            MODE_SOFT: begin
                if (!lock_nxt)  state_d = MODE_OPEN;
                else if (!wp_n) state_d = MODE_HARD;
            end
            MODE_HARD: if (wp_n) state_d = MODE_SOFT;
            default:   state_d = MODE_OPEN;
        endcase
    end

    always_comb begin
        mode      = state_q;
        hard_lock = (state_q == MODE_HARD);
    end

endmodule

// File: rtl/bp_region_check.sv
module bp_region_check
    import flash_wp_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int SEC_W  = 16
) (
    input  logic [BP_W-1:0]   bp,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);

    localparam int SIDX_W    = ADDR_W - SEC_W;
    localparam int FULL_CODE = SIDX_W + 1;
    localparam logic [SIDX_W:0] NUM_SEC = {1'b1, {SIDX_W{1'b0}}};

    logic [SIDX_W-1:0] sector;
    logic [SIDX_W:0]   span;
    logic [SIDX_W:0]   floor_sec;

    assign sector = addr[ADDR_W-1:SEC_W];

    always_comb begin
        span      = '0;
        floor_sec = NUM_SEC;
        hit       = 1'b0;
        if (bp == '0) begin
            hit = 1'b0;
        end else if (int'(bp) >= FULL_CODE) begin
            hit = 1'b1;
        end else begin
            span      = (SIDX_W+1)'(1) << (bp - BP_W'(1));
            floor_sec = NUM_SEC - span;
            hit       = ({1'b0, sector} >= floor_sec);
        end
    end

endmodule

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl
    import flash_wp_pkg::*;
#(
    parameter int ADDR_W    = 21,
    parameter int SEC_W     = 16,
    parameter int OP_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_n,
    input  logic              cmd_wren,
    input  logic              cmd_wrdi,
    input  logic              cmd_wrsr,
    input  logic              cmd_prog,
    input  logic              cmd_erase_sec,
    input  logic              cmd_erase_page,
    input  logic              cmd_erase_bulk,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_lockbit,
    input  logic [2:0]        wr_bp,
    output logic              sr_lockbit,
    output logic [2:0]        sr_bp,
    output logic              sr_wel,
    output logic              sr_busy,
    output logic              hw_locked,
    output logic              op_accept,
    output logic              op_reject
);

    localparam int CNT_W = $clog2(OP_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(OP_CYCLES);

    op_e              op;
    wp_mode_e         mode;
    logic             hard_lock;
    logic             region_hit;
    logic             lock_q, lock_d;
    logic [BP_W-1:0]  bp_q, bp_d;
    logic             wel_q, wel_d;
    logic             acc_q, acc_d;
    logic             rej_q, rej_d;
    logic             start_op;
    logic [CNT_W-1:0] busy_cnt;

    always_comb begin
        if (cmd_wrsr)            op = OP_WRSR;
        else if (cmd_prog)       op = OP_PROG;
        else if (cmd_erase_sec)  op = OP_ERASE_SEC;
        else if (cmd_erase_page) op = OP_ERASE_PAGE;
        else if (cmd_erase_bulk) op = OP_ERASE_BULK;
        else if (cmd_wren)       op = OP_WREN;
        else if (cmd_wrdi)       op = OP_WRDI;
        else                     op = OP_NONE;
    end

    bp_region_check #(
        .ADDR_W (ADDR_W),
        .SEC_W  (SEC_W)
    ) u_region (
        .bp   (bp_q),
        .addr (addr),
        .hit  (region_hit)
    );

    wp_mode_fsm u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .lock_nxt  (lock_d),
        .wp_n      (wp_n),
        .mode      (mode),
        .hard_lock (hard_lock)
    );

    always_comb begin
        lock_d   = lock_q;
        bp_d     = bp_q;
        wel_d    = wel_q;
        acc_d    = 1'b0;
        rej_d    = 1'b0;
        start_op = 1'b0;
        if (busy_cnt == '0) begin
            unique case (op)
                OP_WREN: wel_d = 1'b1;
                OP_WRDI: wel_d = 1'b0;
                OP_WRSR: begin
                    if (wel_q && (mode != MODE_HARD)) begin
                        lock_d   = wr_lockbit;
                        bp_d     = wr_bp;
                        wel_d    = 1'b0;
                        acc_d    = 1'b1;
                        start_op = 1'b1;
                    end else begin
                        rej_d = 1'b1;
                    end
                end
                OP_PROG, OP_ERASE_SEC, OP_ERASE_PAGE: begin
                    wel_d = 1'b0;
                    if (wel_q && !region_hit) begin
                        acc_d    = 1'b1;
                        start_op = 1'b1;
                    end else begin
                        rej_d = 1'b1;
                    end
                end
                OP_ERASE_BULK: begin
                    wel_d = 1'b0;
                    if (wel_q && (bp_q == '0)) begin
                        acc_d    = 1'b1;
                        start_op = 1'b1;
                    end else begin
                        rej_d = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_q   <= 1'b0;
            bp_q     <= '0;
            wel_q    <= 1'b0;
            acc_q    <= 1'b0;
            rej_q    <= 1'b0;
            busy_cnt <= '0;
        end else begin
            lock_q <= lock_d;
            bp_q   <= bp_d;
            wel_q  <= wel_d;
            acc_q  <= acc_d;
            rej_q  <= rej_d;
            if (start_op)            busy_cnt <= CNT_LOAD;
            else if (busy_cnt != '0) busy_cnt <= busy_cnt - CNT_W'(1);
        end
    end

    assign sr_lockbit = lock_q;
    assign sr_bp      = bp_q;
    assign sr_wel     = wel_q;
    assign sr_busy    = (busy_cnt != '0);
    assign hw_locked  = hard_lock;
    assign op_accept  = acc_q;
    assign op_reject  = rej_q;

endmodule

// File: rtl/flash_wp_ctrl_chk.sv
module flash_wp_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wp_n,
    input logic       cmd_wren,
    input logic       cmd_wrdi,
    input logic       cmd_wrsr,
    input logic       cmd_prog,
    input logic       cmd_erase_sec,
    input logic       cmd_erase_page,
    input logic       cmd_erase_bulk,
    input logic       sr_lockbit,
    input logic [2:0] sr_bp,
    input logic       sr_wel,
    input logic       sr_busy,
    input logic       hw_locked,
    input logic       op_accept,
    input logic       op_reject
);

    logic mod_req;
    logic wren_only;
    assign mod_req   = cmd_prog | cmd_erase_sec | cmd_erase_page | cmd_erase_bulk;
    assign wren_only = cmd_wren & ~cmd_wrsr & ~mod_req;

    p_wel_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wren_only && !sr_busy) |=> sr_wel);

    p_wrsr_nowel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wrsr && !sr_wel && !sr_busy) |=> (op_reject && $stable(sr_bp) && $stable(sr_lockbit)));

    p_hard_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wrsr && hw_locked && !sr_busy) |=> (op_reject && $stable(sr_bp) && $stable(sr_lockbit)));

    p_hard_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_locked && !wp_n) |=> hw_locked);

    p_hard_lockbit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hw_locked |-> sr_lockbit);

    p_bulk_refuse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_erase_bulk && !cmd_wrsr && !cmd_prog && !cmd_erase_sec && !cmd_erase_page
         && (sr_bp != 3'd0) && !sr_busy) |=> op_reject);

    p_wel_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_req && !cmd_wrsr && !sr_busy) |=> !sr_wel);

    p_busy_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sr_busy |=> (!op_accept && !op_reject));

    p_accept_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        op_accept |-> sr_busy);

endmodule

bind flash_wp_ctrl flash_wp_ctrl_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .wp_n           (wp_n),
    .cmd_wren       (cmd_wren),
    .cmd_wrdi       (cmd_wrdi),
    .cmd_wrsr       (cmd_wrsr),
    .cmd_prog       (cmd_prog),
    .cmd_erase_sec  (cmd_erase_sec),
    .cmd_erase_page (cmd_erase_page),
    .cmd_erase_bulk (cmd_erase_bulk),
    .sr_lockbit     (sr_lockbit),
    .sr_bp          (sr_bp),
    .sr_wel         (sr_wel),
    .sr_busy        (sr_busy),
    .hw_locked      (hw_locked),
    .op_accept      (op_accept),
    .op_reject      (op_reject)
);

// File: tb/flash_wp_ctrl_bench.sv
`timescale 1ns/1ps
module flash_wp_ctrl_bench;

    localparam int ADDR_W = 21;
    localparam int OPC    = 4;

    localparam int K_WREN = 1, K_WRDI = 2, K_WRSR = 3, K_PROG = 4,
                   K_ESEC = 5, K_EPAGE = 6, K_EBULK = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wp_n = 1'b1;
    logic cmd_wren = 0, cmd_wrdi = 0, cmd_wrsr = 0, cmd_prog = 0;
    logic cmd_erase_sec = 0, cmd_erase_page = 0, cmd_erase_bulk = 0;
    logic [ADDR_W-1:0] addr = '0;
    logic wr_lockbit = 0;
    logic [2:0] wr_bp = '0;
    logic sr_lockbit, sr_wel, sr_busy, hw_locked, op_accept, op_reject;
    logic [2:0] sr_bp;

    always #2.5 clk = ~clk;

    flash_wp_ctrl #(.ADDR_W(ADDR_W), .SEC_W(16), .OP_CYCLES(OPC)) u_flash_wp_ctrl (
        .clk(clk), .rst_n(rst_n), .wp_n(wp_n),
        .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_wrsr(cmd_wrsr),
        .cmd_prog(cmd_prog), .cmd_erase_sec(cmd_erase_sec),
        .cmd_erase_page(cmd_erase_page), .cmd_erase_bulk(cmd_erase_bulk),
        .addr(addr), .wr_lockbit(wr_lockbit), .wr_bp(wr_bp),
        .sr_lockbit(sr_lockbit), .sr_bp(sr_bp), .sr_wel(sr_wel), .sr_busy(sr_busy),
        .hw_locked(hw_locked), .op_accept(op_accept), .op_reject(op_reject)
    );

    typedef struct {
        logic [8:0] img;
        string      tag;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    bit       m_lock = 0;
    bit [2:0] m_bp = 0;
    bit       m_wel = 0;
    int       m_busy = 0;
    bit       m_wpq = 1;

    function automatic bit in_region(bit [2:0] code, logic [ADDR_W-1:0] a);
        int sec;
        sec = int'(a[20:16]);
        if (code == 0) return 0;
        if (code >= 6) return 1;
        return sec >= 32 - (1 << (code - 1));
    endfunction

    task automatic clear_inputs();
        cmd_wren = 0; cmd_wrdi = 0; cmd_wrsr = 0; cmd_prog = 0;
        cmd_erase_sec = 0; cmd_erase_page = 0; cmd_erase_bulk = 0;
    endtask

    task automatic idle(input bit pin, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            clear_inputs();
            wp_n = pin;
            m_wpq = pin;
            if (m_busy > 0) m_busy--;
            @(posedge clk);
        end
    endtask

    task automatic send(input int kind, input logic [ADDR_W-1:0] a,
                        input bit lk, input bit [2:0] code, input bit pin, input string tag);
        bit acc, rej, hard_now;
        exp_t e;
        @(negedge clk);
        clear_inputs();
        addr = a; wr_lockbit = lk; wr_bp = code; wp_n = pin;
        case (kind)
            K_WREN:  cmd_wren = 1;
            K_WRDI:  cmd_wrdi = 1;
            K_WRSR:  cmd_wrsr = 1;
            K_PROG:  cmd_prog = 1;
            K_ESEC:  cmd_erase_sec = 1;
            K_EPAGE: cmd_erase_page = 1;
            default: cmd_erase_bulk = 1;
        endcase
        acc = 0; rej = 0;
        hard_now = m_lock && !m_wpq;
        if (m_busy == 0) begin
            case (kind)
                K_WREN: m_wel = 1;
                K_WRDI: m_wel = 0;
                K_WRSR: begin
                    if (m_wel && !hard_now) begin
                        m_lock = lk; m_bp = code; m_wel = 0; acc = 1;
                    end else rej = 1;
                end
                K_EBULK: begin
                    if (m_wel && m_bp == 0) acc = 1; else rej = 1;
                    m_wel = 0;
                end
                default: begin
                    if (m_wel && !in_region(m_bp, a)) acc = 1; else rej = 1;
                    m_wel = 0;
                end
            endcase
        end
        if (acc) m_busy = OPC;
        else if (m_busy > 0) m_busy--;
        m_wpq = pin;
        e.img = {acc, rej, m_lock, m_bp, m_wel, (m_busy != 0), (m_lock && !pin)};
        e.tag = tag;
        q.push_back(e);
        @(posedge clk);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                logic [8:0] act;
                e = q.pop_front();
                act = {op_accept, op_reject, sr_lockbit, sr_bp, sr_wel, sr_busy, hw_locked};
                checks++;
                if (act !== e.img) begin
                    errors++;
                    $display("FAIL %s: actual acc/rej/lk/bp/wel/busy/hw=%b expected %b", e.tag, act, e.img);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 100000);
        errors++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if ({op_accept, op_reject, sr_lockbit, sr_bp, sr_wel, sr_busy, hw_locked} !== 9'b0) begin
            errors++;
            $display("FAIL R1 reset: actual %b expected %b",
                     {op_accept, op_reject, sr_lockbit, sr_bp, sr_wel, sr_busy, hw_locked}, 9'b0);
        end
        @(negedge clk);
        rst_n = 1;
        idle(1, 1);

        send(K_WRSR, 0, 0, 3'd3, 1, "R3 write without latch");
        send(K_WREN, 0, 0, 0, 1, "R2 latch set");
        send(K_WRDI, 0, 0, 0, 1, "R2 latch cleared");
        send(K_WREN, 0, 0, 0, 1, "R2 latch set again");
        idle(0, 2);
        send(K_WRSR, 0, 0, 3'd3, 0, "R4 write accepted with pin low");
        send(K_WREN, 0, 0, 0, 0, "R11 ignored while busy");
        idle(0, OPC);

        send(K_WREN, 0, 0, 0, 0, "R2 latch before program");
        send(K_PROG, 21'h1F0000, 0, 0, 0, "R8 program top sector refused");
        send(K_WREN, 0, 0, 0, 0, "R2 latch");
        send(K_PROG, 21'h1BFFFF, 0, 0, 0, "R8 program sector 27 accepted");
        idle(0, OPC);
        send(K_WREN, 0, 0, 0, 0, "R2 latch");
        send(K_ESEC, 21'h1C0000, 0, 0, 0, "R8 sector erase at boundary refused");
        send(K_WREN, 0, 0, 0, 0, "R2 latch");
        send(K_EBULK, 0, 0, 0, 0, "R9 bulk erase refused with nonzero code");
        send(K_PROG, 0, 0, 0, 0, "R10 program without latch refused");

        idle(1, 2);
        send(K_WREN, 0, 0, 0, 1, "R2 latch");
        send(K_WRSR, 0, 1, 3'd1, 1, "R5 set lock bit with pin high");
        idle(1, OPC);
        send(K_WREN, 0, 0, 0, 1, "R2 latch");
        send(K_WRSR, 0, 1, 3'd2, 1, "R5 write with lock bit 1 and pin high");
        idle(1, OPC);
        idle(0, 2);
        send(K_WREN, 0, 0, 0, 0, "R7 hard lock after pin falls");
        send(K_WRSR, 0, 0, 3'd0, 0, "R6 write refused in hard lock");
        idle(1, 2);
        send(K_WRSR, 0, 1, 3'd5, 1, "R7 exit by pin high then write accepted");
        idle(1, OPC);
        send(K_WREN, 0, 0, 0, 1, "R2 latch");
        send(K_WRSR, 0, 0, 3'd0, 1, "R4 clear lock bit");
        idle(1, OPC);

        idle(0, 2);
        send(K_WREN, 0, 0, 0, 0, "R2 latch");
        send(K_WRSR, 0, 1, 3'd2, 0, "R7 lock set after pin low enters hard lock");
        idle(0, OPC);
        send(K_WREN, 0, 0, 0, 0, "R2 latch in hard lock");
        send(K_WRSR, 0, 0, 3'd0, 0, "R6 refused after lock-second entry");

        idle(1, 2);
        send(K_WREN, 0, 0, 0, 1, "R2 latch");
        send(K_WRSR, 0, 1, 3'd6, 0, "R12 pin falls with write: old pin rules");
        idle(0, OPC);
        send(K_WREN, 0, 0, 0, 0, "R2 latch");
        send(K_PROG, 21'h000000, 0, 0, 0, "R8 code 6 protects bottom sector");

        idle(1, 2);
        send(K_WREN, 0, 0, 0, 1, "R2 latch");
        send(K_WRSR, 0, 0, 3'd0, 1, "R4 clear code");
        idle(1, OPC);
        send(K_WREN, 0, 0, 0, 1, "R2 latch");
        send(K_EBULK, 0, 0, 0, 1, "R9 bulk erase accepted with code 0");
        idle(1, OPC);
        send(K_WREN, 0, 0, 0, 1, "R2 latch");
        send(K_EPAGE, 21'h1FFF00, 0, 0, 1, "R8 page erase accepted with code 0");
        idle(1, OPC);

        send(K_WREN, 0, 0, 0, 1, "R2 latch");
        send(K_WRSR, 0, 1, 3'd0, 1, "R5 set lock bit");
        idle(1, OPC);
        idle(0, 2);
        send(K_WREN, 0, 0, 0, 0, "R2 latch in hard lock");
        send(K_WRSR, 0, 0, 3'd4, 1, "R12 pin rises with write: old pin rules");
        idle(1, 2);

        finish_run();
    end

endmodule